// File: doc/BRIEF.md
# Per-Packet Crypto Context Capture

This block watches the ingress of a packet stream (valid, ready, last) and takes a snapshot of the per-packet cryptographic sideband on the first beat of each packet. The sideband carries a security-association index, an externally supplied key, a cipher-suite select, a confidentiality offset, a 96-bit IV, a bypass flag and an auth-only flag. The block then presents one stable context record that downstream cipher and hash logic can use for the whole packet.

The working key is resolved from the index. Indexes below the internal table depth (0 to 1023 by default) read a small on-chip key table, which has its own synchronous write port. Indexes at or above that depth take the external key. For the 128-bit suite the upper half of the key is forced to zero.

During the first beat the context follows the live sideband, so it is usable in the same cycle. After that beat is accepted, the registered copy is held until the beat that carries last has been accepted.

Top module: `crypto_ctx_capture`

## Requirements
- R1: After reset, and whenever no packet is open and valid_i is low, ctx_valid_o is 0 and every context output is 0.
- R2: While the first beat of a packet is presented (valid_i high, no packet open), ctx_valid_o is 1 and the context outputs reflect the live sideband inputs in the same cycle.
- R3: Once the first beat is accepted (valid_i and ready_i high) without last, the context is captured. It stays constant, with ctx_valid_o high, whatever the sideband inputs do on later beats, until the beat carrying last is accepted.
- R4: ctx_valid_o falls in the cycle after the beat carrying last is accepted, unless a new first beat is presented. A packet of one beat (first beat also carries last) opens no packet.
- R5: An SA index from 0 to INT_KEYS-1 (1023 by default) selects the internal table entry at that index, and ext_key_i is ignored.
- R6: An SA index of INT_KEYS or more selects ext_key_i.
- R7: suite_i = 0 selects the 128-bit-key GCM-AES suite: key bits 255:128 read 0 and bits 127:0 come from the selected source. suite_i = 1 selects the 256-bit suite and passes all 256 bits.
- R8: The 96-bit IV, the 6-bit confidentiality offset (0 to 63 bytes), the bypass flag, the auth-only flag, the suite and the SA index are carried into the context unchanged.
- R9: A table write (kt_we_i high at a clock edge) is visible to first beats in later cycles. A first beat in the same cycle as a write to its index sees the old key.
- R10: A table write to the index of a packet in flight does not change that packet's captured key.
- R11: A first beat held with ready_i low is not captured: the context keeps following the live sideband until the beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Ingress beat valid |
| ready_i | input | 1 | Ingress beat ready (beat accepted when both high) |
| last_i | input | 1 | Ingress beat is the last of its packet |
| sa_idx_i | input | 11 | Security-association index |
| ext_key_i | input | 256 | Externally supplied key |
| suite_i | input | 1 | 0: 128-bit-key GCM-AES, 1: 256-bit-key GCM-AES |
| conf_off_i | input | 6 | Confidentiality offset in bytes |
| iv_i | input | 96 | Initialization vector |
| bypass_i | input | 1 | Packet bypasses cipher and authentication |
| auth_only_i | input | 1 | Packet is authenticated only |
| kt_we_i | input | 1 | Key table write enable |
| kt_waddr_i | input | 10 | Key table write index |
| kt_wkey_i | input | 256 | Key table write data |
| ctx_valid_o | output | 1 | Context record valid |
| ctx_sa_idx_o | output | 11 | Context SA index |
| ctx_key_o | output | 256 | Resolved working key |
| ctx_suite_o | output | 1 | Context cipher suite |
| ctx_conf_off_o | output | 6 | Context confidentiality offset |
| ctx_iv_o | output | 96 | Context IV |
| ctx_bypass_o | output | 1 | Context bypass flag |
| ctx_auth_only_o | output | 1 | Context auth-only flag |

## Verification
The context is due in the same cycle as a presented first beat, because it is forwarded combinationally from the sideband and the table read. The captured copy takes over at the edge that accepts that beat, and ctx_valid_o drops at the edge that accepts the last beat. A table write takes effect at its edge, so only first beats in later cycles see it. The bench drives inputs on the falling edge and samples one time unit later, so each check sees the result of the preceding rising edge plus the current combinational path. Each check is timed from those edge counts, and the bench's own key table model is updated only at the edge where a write lands.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int SA_W   = 11;
  localparam int KEY_W  = 256;
  localparam int HALF_W = KEY_W / 2;
  localparam int IV_W   = 96;
  localparam int OFF_W  = 6;

  typedef enum logic {
    SUITE_G128 = 1'b0,
    SUITE_G256 = 1'b1
  } suite_e;

  typedef struct packed {
    logic [SA_W-1:0]  sa_idx;
    logic [KEY_W-1:0] key;
    suite_e           suite;
    logic [OFF_W-1:0] conf_off;
    logic [IV_W-1:0]  iv;
    logic             bypass;
    logic             auth_only;
  } ctx_t;
endpackage

// File: rtl/ctx_keytab.sv
module ctx_keytab
  import ctx_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [KEY_W-1:0] wkey_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [KEY_W-1:0] rkey_o
);
  logic [KEY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wkey_i;
  end

  // read-old on same-cycle write
  assign rkey_o = mem_q[raddr_i];

  // R9
  tab_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wkey_i));
endmodule

// File: rtl/ctx_key_sel.sv
module ctx_key_sel
  import ctx_pkg::*;
#(
  parameter int INT_KEYS = 1024,
  localparam int AW      = $clog2(INT_KEYS)
) (
  input  logic [SA_W-1:0]  sa_idx_i,
  input  logic [KEY_W-1:0] ext_key_i,
  input  suite_e           suite_i,
  input  logic [KEY_W-1:0] tbl_key_i,
  output logic [AW-1:0]    tbl_raddr_o,
  output logic [KEY_W-1:0] key_o
);
  logic             is_int;
  logic [KEY_W-1:0] raw_key;

  assign is_int      = {1'b0, sa_idx_i} < (SA_W+1)'(INT_KEYS);
  assign tbl_raddr_o = sa_idx_i[AW-1:0];
  assign raw_key     = is_int ? tbl_key_i : ext_key_i;

  always_comb begin
    key_o = raw_key;
    if (suite_i == SUITE_G128) key_o[KEY_W-1:HALF_W] = '0;
  end
endmodule

// File: rtl/ctx_pkt_track.sv
module ctx_pkt_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ready_i,
  input  logic last_i,
  output logic in_pkt_o,
  output logic sop_fire_o,
  output logic eop_fire_o
);
  logic fire, in_pkt_q;

  assign fire       = valid_i & ready_i;
  assign sop_fire_o = fire & ~in_pkt_q;
  assign eop_fire_o = fire & last_i;
  assign in_pkt_o   = in_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         in_pkt_q <= 1'b0;
    else if (eop_fire_o) in_pkt_q <= 1'b0;
    else if (sop_fire_o) in_pkt_q <= 1'b1;
  end

  // R4
  eop_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && last_i) |=> !in_pkt_q);
  // R3
  sop_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && !last_i && !in_pkt_q) |=> in_pkt_q);
  // R11
  stall_no_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_pkt_q && !(valid_i && ready_i)) |=> !in_pkt_q);
endmodule

// File: rtl/ctx_hold.sv
module ctx_hold
  import ctx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic in_pkt_i,
  input  logic sop_fire_i,
  input  logic eop_fire_i,
  input  ctx_t live_i,
  output logic ctx_valid_o,
  output ctx_t ctx_o
);
  ctx_t cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cap_q <= '0;
    else if (sop_fire_i) cap_q <= live_i;
  end

  assign ctx_valid_o = in_pkt_i | valid_i;

  always_comb begin
    if (in_pkt_i)     ctx_o = cap_q;
    else if (valid_i) ctx_o = live_i;
    else              ctx_o = '0;
  end

  // R3
  ctx_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pkt_i && !eop_fire_i) |=> ($stable(ctx_o) && ctx_valid_o));
  // R7
  narrow_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_valid_o && ctx_o.suite == SUITE_G128) |-> ctx_o.key[KEY_W-1:HALF_W] == '0);
  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctx_valid_o |-> ctx_o == '0);
endmodule

// File: rtl/crypto_ctx_capture.sv
module crypto_ctx_capture
  import ctx_pkg::*;
#(
  parameter int INT_KEYS = 1024,
  localparam int AW      = $clog2(INT_KEYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             last_i,
  input  logic [SA_W-1:0]  sa_idx_i,
  input  logic [KEY_W-1:0] ext_key_i,
  input  logic             suite_i,
  input  logic [OFF_W-1:0] conf_off_i,
  input  logic [IV_W-1:0]  iv_i,
  input  logic             bypass_i,
  input  logic             auth_only_i,
  input  logic             kt_we_i,
  input  logic [AW-1:0]    kt_waddr_i,
  input  logic [KEY_W-1:0] kt_wkey_i,
  output logic             ctx_valid_o,
  output logic [SA_W-1:0]  ctx_sa_idx_o,
  output logic [KEY_W-1:0] ctx_key_o,
  output logic             ctx_suite_o,
  output logic [OFF_W-1:0] ctx_conf_off_o,
  output logic [IV_W-1:0]  ctx_iv_o,
  output logic             ctx_bypass_o,
  output logic             ctx_auth_only_o
);
  logic [AW-1:0]    tbl_raddr;
  logic [KEY_W-1:0] tbl_key, res_key;
  logic             in_pkt, sop_fire, eop_fire;
  ctx_t             live, ctx;
  suite_e           suite;

  assign suite = suite_e'(suite_i);

  ctx_keytab #(.DEPTH(INT_KEYS)) u_tab (
    .clk_i, .rst_ni,
    .we_i(kt_we_i), .waddr_i(kt_waddr_i), .wkey_i(kt_wkey_i),
    .raddr_i(tbl_raddr), .rkey_o(tbl_key)
  );

  ctx_key_sel #(.INT_KEYS(INT_KEYS)) u_sel (
    .sa_idx_i, .ext_key_i, .suite_i(suite),
    .tbl_key_i(tbl_key), .tbl_raddr_o(tbl_raddr), .key_o(res_key)
  );

  ctx_pkt_track u_trk (
    .clk_i, .rst_ni, .valid_i, .ready_i, .last_i,
    .in_pkt_o(in_pkt), .sop_fire_o(sop_fire), .eop_fire_o(eop_fire)
  );

  always_comb begin
    live           = '0;
    live.sa_idx    = sa_idx_i;
    live.key       = res_key;
    live.suite     = suite;
    live.conf_off  = conf_off_i;
    live.iv        = iv_i;
    live.bypass    = bypass_i;
    live.auth_only = auth_only_i;
  end

  ctx_hold u_hold (
    .clk_i, .rst_ni, .valid_i,
    .in_pkt_i(in_pkt), .sop_fire_i(sop_fire), .eop_fire_i(eop_fire),
    .live_i(live), .ctx_valid_o, .ctx_o(ctx)
  );

  assign ctx_sa_idx_o    = ctx.sa_idx;
  assign ctx_key_o       = ctx.key;
  assign ctx_suite_o     = ctx.suite;
  assign ctx_conf_off_o  = ctx.conf_off;
  assign ctx_iv_o        = ctx.iv;
  assign ctx_bypass_o    = ctx.bypass;
  assign ctx_auth_only_o = ctx.auth_only;

  // R6
  ext_key_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_pkt && {1'b0, sa_idx_i} >= (SA_W+1)'(INT_KEYS) && suite_i)
      |-> ctx_key_o == ext_key_i);
  // R8
  iv_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i && !in_pkt && !last_i) |=> ctx_iv_o == $past(iv_i));
endmodule

// File: tb/crypto_ctx_capture_tb_top.sv
module crypto_ctx_capture_tb_top;
  import ctx_pkg::*;
  localparam int CLK_P    = 10;
  localparam int INT_KEYS = 1024;
  localparam int AW       = $clog2(INT_KEYS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 0, ready_i = 0, last_i = 0;
  logic [SA_W-1:0]  sa_idx_i = '0;
  logic [KEY_W-1:0] ext_key_i = '0;
  logic             suite_i = 0;
  logic [OFF_W-1:0] conf_off_i = '0;
  logic [IV_W-1:0]  iv_i = '0;
  logic             bypass_i = 0, auth_only_i = 0;
  logic             kt_we_i = 0;
  logic [AW-1:0]    kt_waddr_i = '0;
  logic [KEY_W-1:0] kt_wkey_i = '0;
  logic             ctx_valid_o, ctx_suite_o, ctx_bypass_o, ctx_auth_only_o;
  logic [SA_W-1:0]  ctx_sa_idx_o;
  logic [KEY_W-1:0] ctx_key_o;
  logic [OFF_W-1:0] ctx_conf_off_o;
  logic [IV_W-1:0]  ctx_iv_o;

  logic [KEY_W-1:0] ref_tab [INT_KEYS];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  crypto_ctx_capture #(.INT_KEYS(INT_KEYS)) dut_i (
    .clk_i(clk), .rst_ni, .valid_i, .ready_i, .last_i, .sa_idx_i, .ext_key_i,
    .suite_i, .conf_off_i, .iv_i, .bypass_i, .auth_only_i, .kt_we_i, .kt_waddr_i,
    .kt_wkey_i, .ctx_valid_o, .ctx_sa_idx_o, .ctx_key_o, .ctx_suite_o,
    .ctx_conf_off_o, .ctx_iv_o, .ctx_bypass_o, .ctx_auth_only_o
  );

  function automatic logic [KEY_W-1:0] mk_key(int s);
    logic [KEY_W-1:0] r;
    for (int k = 0; k < KEY_W/32; k++)
      r[k*32 +: 32] = (32'(s) * 32'h9E37_79B1 + 32'(k) * 32'h0100_0193) ^ 32'hA5A5_0000;
    return r;
  endfunction

  function automatic ctx_t exp_ctx(int idx, logic [KEY_W-1:0] ext, logic st,
                                   logic [OFF_W-1:0] off, logic [IV_W-1:0] iv,
                                   logic byp, logic ao);
    ctx_t e;
    e.sa_idx    = SA_W'(idx);
    e.key       = (idx < INT_KEYS) ? ref_tab[idx] : ext;
    if (!st) e.key[KEY_W-1:HALF_W] = '0;
    e.suite     = suite_e'(st);
    e.conf_off  = off;
    e.iv        = iv;
    e.bypass    = byp;
    e.auth_only = ao;
    return e;
  endfunction

  task automatic check(string req, logic exp_v, ctx_t exp);
    ctx_t act;
    act = {ctx_sa_idx_o, ctx_key_o, suite_e'(ctx_suite_o), ctx_conf_off_o,
           ctx_iv_o, ctx_bypass_o, ctx_auth_only_o};
    n_chk++;
    if (ctx_valid_o !== exp_v || act !== exp) begin
      n_fail++;
      $display("FAIL %s: valid=%b ctx=%h expected valid=%b ctx=%h",
               req, ctx_valid_o, act, exp_v, exp);
    end
  endtask

  // drive sideband from a seed, return the expected context
  task automatic drive_sb(int idx, logic st, int seed, output ctx_t e);
    logic [KEY_W-1:0] ext;
    logic [IV_W-1:0]  iv;
    logic [OFF_W-1:0] off;
    ext = mk_key(seed + 7000);
    iv  = {32'(seed) ^ 32'hC0DE_0000, 32'(idx), 32'h1234_0000 | 32'(st)};
    off = OFF_W'(seed * 7 + 32'(st));
    sa_idx_i = SA_W'(idx); ext_key_i = ext; suite_i = st;
    conf_off_i = off; iv_i = iv; bypass_i = seed[0]; auth_only_i = seed[1];
    e = exp_ctx(idx, ext, st, off, iv, seed[0], seed[1]);
  endtask

  task automatic junk_sb();
    sa_idx_i = ~sa_idx_i; ext_key_i = ~ext_key_i; suite_i = ~suite_i;
    conf_off_i = conf_off_i + 1; iv_i = ~iv_i;
    bypass_i = ~bypass_i; auth_only_i = ~auth_only_i;
  endtask

  task automatic write_key(int idx, logic [KEY_W-1:0] k);
    @(negedge clk);
    kt_we_i = 1; kt_waddr_i = AW'(idx); kt_wkey_i = k;
    @(negedge clk);
    kt_we_i = 0;
    ref_tab[idx] = k;
  endtask

  task automatic send_pkt(int idx, logic st, int nbeats, int seed);
    ctx_t e;
    @(negedge clk);
    valid_i = 1; ready_i = 1; last_i = (nbeats == 1);
    drive_sb(idx, st, seed, e);
    #1 check((idx < INT_KEYS) ? "R2/R5/R7/R8" : "R2/R6/R7/R8", 1'b1, e);
    for (int b = 1; b < nbeats; b++) begin
      @(negedge clk);
      kt_we_i = 0;
      junk_sb();
      last_i = (b == nbeats - 1);
      if (b == 1 && idx < INT_KEYS) begin
        kt_we_i = 1; kt_waddr_i = AW'(idx); kt_wkey_i = mk_key(seed + 999);
        ref_tab[idx] = kt_wkey_i;
      end
      #1 check("R3/R10", 1'b1, e);
    end
    @(negedge clk);
    kt_we_i = 0; valid_i = 0; last_i = 0;
    #1 check("R4", 1'b0, '0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int idx_list[8] = '{0, 5, 15, 1008, 1023, 1024, 1500, 2047};
    ctx_t e;
    int seed = 1;
    #(CLK_P * 2 + 1);
    check("R1", 1'b0, '0);
    @(negedge clk) rst_ni = 1;
    #1 check("R1", 1'b0, '0);

    for (int i = 0; i < 16; i++) write_key(i, mk_key(i));
    for (int i = 1008; i < 1024; i++) write_key(i, mk_key(i));

    // sweep index range x suite x packet length
    foreach (idx_list[j])
      for (int st = 0; st < 2; st++)
        for (int nb = 1; nb <= 3; nb += 2) begin
          send_pkt(idx_list[j], st[0], nb, seed);
          seed++;
        end

    // R9: same-cycle write to the index being read returns the old key
    @(negedge clk);
    valid_i = 1; ready_i = 1; last_i = 0;
    drive_sb(3, 1'b1, 77, e);
    kt_we_i = 1; kt_waddr_i = 3; kt_wkey_i = mk_key(4321);
    #1 check("R9", 1'b1, e);
    @(negedge clk);
    kt_we_i = 0; last_i = 1; junk_sb();
    ref_tab[3] = mk_key(4321);
    #1 check("R9/R10", 1'b1, e);
    @(negedge clk);
    valid_i = 0; last_i = 0;
    #1 check("R4", 1'b0, '0);
    send_pkt(3, 1'b1, 1, 78);   // R9: new key visible now

    // R11: stalled first beat keeps following live sideband
    @(negedge clk);
    valid_i = 1; ready_i = 0; last_i = 0;
    drive_sb(1024, 1'b0, 90, e);
    #1 check("R11", 1'b1, e);
    @(negedge clk);
    drive_sb(1300, 1'b1, 91, e);
    #1 check("R11", 1'b1, e);
    @(negedge clk);
    ready_i = 1;
    #1 check("R11", 1'b1, e);
    @(negedge clk);
    junk_sb(); last_i = 1;
    #1 check("R3/R11", 1'b1, e);
    @(negedge clk);
    valid_i = 0; last_i = 0;
    #1 check("R4", 1'b0, '0);

    // R5: ext key ignored for internal index under 256-bit suite
    send_pkt(1023, 1'b1, 2, 200);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule